// File: doc/BRIEF.md
# Switching Clock Synchronizer

This block sets the switching rate of a PWM power stage. It can also take that rate from another instance, so that several stages in one system switch at the same frequency. A static role strap chooses how it works. As master, it divides the system clock by a programmed ratio and drives the shared sync pin with a square wave. Each switching period holds two sync periods, so the pin runs at twice the switching rate. As slave, it receives that wave on the same pin. It resynchronises the wave, detects its rising edges and halves the rate. It can then rebuild the same switching period locally.

Both roles give the modulator the same two outputs. One is a single-cycle tick at the start of each switching period. The other is a phase bit that tells which half of the period is running. In slave mode a watchdog raises an error flag when the sync wave stops. The bidirectional pin is modelled as a separate input, a separate output and an output enable.

Top module: `swsync_top`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, syncOe is 0. swPhase and lostClk are also 0 during reset.
- R2: As master, syncOut repeats every L system clocks, where L is periodCfg, with any value below 2 treated as 2. syncOut is high for the first floor(L/2) clocks of each repetition and low for the rest.
- R3: As master, swTick pulses in the first cycle after reset release and then every 2·L cycles. swPhase is 0 during the first L cycles of a switching period and 1 during the second L cycles.
- R4: syncOe is 1 from the first clock edge after reset while roleMaster is 1. It stays 0, and syncOut stays 0, while roleMaster is 0 (slave).
- R5: As master, the level and activity of syncIn have no effect on syncOut, swTick or swPhase.
- R6: As slave, syncIn passes through two synchronising flops before its rising edges are detected. A rise that is first sampled at clock edge e is detected in the cycle after edge e+1. swPhase toggles at the next edge. swTick pulses in the detection cycle of the 2nd, 4th, 6th and later detected rises.
- R7: swTick is never high in two consecutive cycles.
- R8: As slave, lostClk rises once timeoutCfg (T ≥ 1) clock edges have passed without a detected rise. The count starts at reset release, or at the edge after the last detection. So with no activity after reset, lostClk is 0 after T−1 edges and 1 after T edges.
- R9: A detected sync rise clears lostClk at the next clock edge. lostClk stays 0 while the block is master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| roleMaster | input | 1 | Role strap: 1 master, 0 slave |
| periodCfg | input | CNT_W | Master sync period in system clocks (half a switching period) |
| timeoutCfg | input | WD_W | Slave watchdog limit in system clocks |
| syncIn | input | 1 | Sync pin input value |
| syncOut | output | 1 | Sync pin output value |
| syncOe | output | 1 | Sync pin output enable |
| swTick | output | 1 | One-cycle pulse at the start of each switching period |
| swPhase | output | 1 | Half of the switching period currently running |
| lostClk | output | 1 | Slave has seen no sync edge within the timeout |

## Verification
The embedded properties hold on every cycle:
- the master sync counter stays within the programmed period;
- the phase bit only changes when that counter wraps;
- ticks and detected edges are isolated single cycles;
- the output enable stays low in slave mode;
- the lost-clock flag stays low in master mode.

Only the bench scenarios can show the exact waveform for each period ratio, including the clamped ratios, and that a toggling syncIn has no effect in master mode. The same holds for the two-flop detection latency, the tick on every second slave edge, and the exact cycle in which the watchdog fires and then clears.

// File: rtl/swsync_pkg.sv
`timescale 1ns/1ps
package swsync_pkg;
  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic masterMode;  // role strap as seen by the counters
    logic slaveEdge;   // detected rising edge of the synchronised sync input
  } swStrobe_t;
endpackage

// File: rtl/swsync_ctrl.sv
`timescale 1ns/1ps
module swsync_ctrl
  import swsync_pkg::*;
#(
  parameter int WD_W   = 20,
  parameter int SYNC_N = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            roleMaster,
  input  logic            syncIn,
  input  logic [WD_W-1:0] timeoutCfg,
  output swStrobe_t       strobe,
  output logic            syncOe,
  output logic            lostClk
);
  localparam int PIPE_W = SYNC_N + 1;
  localparam logic [WD_W-1:0] WD_MAX = '1;

  logic [PIPE_W-1:0] syncPipe;
  logic              riseDet;
  logic              oeQ;
  logic [WD_W-1:0]   wdCnt;
  logic              lostQ;
  logic [WD_W:0]     wdNext;

  // Synchroniser chain plus one extra stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[PIPE_W-2:0], syncIn};
  end

  assign riseDet = !roleMaster && syncPipe[SYNC_N-1] && !syncPipe[SYNC_N];

  // Output enable: low in reset, follows the strap afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeQ <= 1'b0;
    else       oeQ <= roleMaster;
  end

  assign wdNext = {1'b0, wdCnt} + 1'b1;

  // Lost-clock watchdog, active only as slave
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
      lostQ <= 1'b0;
    end else if (roleMaster || riseDet) begin
      wdCnt <= '0;
      lostQ <= 1'b0;
    end else begin
      if (wdCnt != WD_MAX) wdCnt <= wdNext[WD_W-1:0];
      if (wdNext >= {1'b0, timeoutCfg}) lostQ <= 1'b1;
    end
  end

  assign strobe.masterMode = roleMaster;
  assign strobe.slaveEdge  = riseDet;
  assign syncOe            = oeQ;
  assign lostClk           = lostQ;

  // R4: pin never driven while the strap has held slave
  p_oe_slave_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!roleMaster && $stable(roleMaster)) |-> !syncOe);

  // R9: no lost-clock error in master mode
  p_lost_master_r9: assert property (@(posedge clk) disable iff (!rstN)
    (roleMaster && $stable(roleMaster)) |-> !lostClk);

  // R7: detected edges are isolated, so slave ticks cannot be back to back
  p_edge_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.slaveEdge |=> !strobe.slaveEdge);
endmodule

// File: rtl/swsync_dp.sv
`timescale 1ns/1ps
module swsync_dp
  import swsync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  swStrobe_t        strobe,
  input  logic [CNT_W-1:0] periodCfg,
  output logic             syncOut,
  output logic             swTick,
  output logic             swPhase
);
  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(2);

  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] limM1;
  logic [CNT_W-1:0] halfLim;
  logic [CNT_W-1:0] cnt;
  logic             half;
  logic             wrap;

  assign lim     = (periodCfg < MIN_LIM) ? MIN_LIM : periodCfg;
  assign limM1   = lim - 1'b1;
  assign halfLim = lim >> 1;
  assign wrap    = strobe.masterMode && (cnt >= limM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (strobe.masterMode) begin
      if (wrap) begin
        cnt  <= '0;
        half <= ~half;
      end else begin
        cnt  <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
      if (strobe.slaveEdge) half <= ~half;
    end
  end

  always_comb begin
    if (strobe.masterMode) begin
      swTick  = (cnt == '0) && !half;
      syncOut = cnt < halfLim;
    end else begin
      swTick  = strobe.slaveEdge && half;
      syncOut = 1'b0;
    end
  end

  assign swPhase = half;

  // R2: master counter stays inside the programmed period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.masterMode && $stable(lim)) |-> (cnt < lim));

  // R3: in master mode the phase only moves when the counter wraps
  p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.masterMode && $stable(strobe.masterMode) && !$stable(swPhase)) |-> (cnt == '0));

  // R7: switching tick is a single-cycle pulse
  p_tick_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    swTick |=> !swTick);
endmodule

// File: rtl/swsync_top.sv
`timescale 1ns/1ps
module swsync_top
  import swsync_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WD_W  = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             roleMaster,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic [WD_W-1:0]  timeoutCfg,
  input  logic             syncIn,
  output logic             syncOut,
  output logic             syncOe,
  output logic             swTick,
  output logic             swPhase,
  output logic             lostClk
);
  swStrobe_t strobe;

  swsync_ctrl #(.WD_W(WD_W), .SYNC_N(2)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .roleMaster (roleMaster),
    .syncIn     (syncIn),
    .timeoutCfg (timeoutCfg),
    .strobe     (strobe),
    .syncOe     (syncOe),
    .lostClk    (lostClk)
  );

  swsync_dp #(.CNT_W(CNT_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .periodCfg (periodCfg),
    .syncOut   (syncOut),
    .swTick    (swTick),
    .swPhase   (swPhase)
  );
endmodule

// File: tb/test_swsync_top.sv
`timescale 1ns/1ps
module test_swsync_top;
  localparam int CNT_W = 16;
  localparam int WD_W  = 20;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             roleMaster = 1'b1;
  logic [CNT_W-1:0] periodCfg = CNT_W'(4);
  logic [WD_W-1:0]  timeoutCfg = WD_W'(1000);
  logic             syncIn = 1'b0;
  logic             syncOut, syncOe, swTick, swPhase, lostClk;

  int nRun = 0;
  int nFail = 0;

  swsync_top #(.CNT_W(CNT_W), .WD_W(WD_W)) i_swsync_top (
    .clk(clk), .rstN(rstN), .roleMaster(roleMaster), .periodCfg(periodCfg),
    .timeoutCfg(timeoutCfg), .syncIn(syncIn), .syncOut(syncOut), .syncOe(syncOe),
    .swTick(swTick), .swPhase(swPhase), .lostClk(lostClk)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string req, input int k, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s sample %0d: actual=%0b expected=%0b", req, k, act, exp);
    end
  endtask

  // Reset with a given role; returns at the negedge where reset is released (sample 0)
  task automatic doReset(input logic role);
    rstN = 1'b0;
    roleMaster = role;
    syncIn = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 oe in reset", -1, syncOe, 1'b0);
    chk("R1 phase in reset", -1, swPhase, 1'b0);
    chk("R1 lost in reset", -1, lostClk, 1'b0);
    rstN = 1'b1;
  endtask

  // Number of slave rises visible before sample m, for a wave with period p starting low
  function automatic int risesBefore(input int m, input int p);
    int first = p / 2 + 2;
    if (m <= first) return 0;
    return (m - 1 - first) / p + 1;
  endfunction

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // Master sweep over ratios, including the clamped values 0 and 1 (R2..R5)
    for (int cfg = 0; cfg <= 9; cfg++) begin
      int lim;
      lim = (cfg < 2) ? 2 : cfg;
      periodCfg = CNT_W'(cfg);
      doReset(1'b1);
      for (int k = 0; k <= 4 * lim + 2; k++) begin
        chk("R2 syncOut", k, syncOut, ((k % lim) < (lim / 2)));
        chk("R3 swTick", k, swTick, ((k % (2 * lim)) == 0));
        chk("R3 swPhase", k, swPhase, (((k / lim) % 2) == 1));
        chk("R4 master oe", k, syncOe, (k >= 1));
        chk("R9 master lost", k, lostClk, 1'b0);
        syncIn = (((k * 7 + cfg) % 3) == 0);  // R5: activity that must not matter
        @(negedge clk);
      end
    end

    // Slave sweep: tick on every second detected rise, phase toggles (R4, R6, R7)
    timeoutCfg = WD_W'(1000);
    for (int p = 4; p <= 9; p++) begin
      doReset(1'b0);
      for (int k = 0; k <= 6 * p + 4; k++) begin
        int d;
        logic expTick;
        d = k - 2 - p / 2;
        expTick = (d >= 0) && ((d % p) == 0) && (((d / p) % 2) == 1);
        chk("R6 slave tick", k, swTick, expTick);
        chk("R6 slave phase", k, swPhase, ((risesBefore(k, p) % 2) == 1));
        chk("R4 slave oe", k, syncOe, 1'b0);
        chk("R4 slave out", k, syncOut, 1'b0);
        if (k >= 1) chk("R7 tick gap", k, swTick && expTick, expTick);
        syncIn = ((k % p) >= (p / 2));
        @(negedge clk);
      end
    end

    // Slave watchdog: exact firing point and clear by one rise (R8, R9)
    begin
      int tmo;
      int kPulse;
      tmo = 20;
      kPulse = 40;
      timeoutCfg = WD_W'(tmo);
      doReset(1'b0);
      for (int k = 0; k <= kPulse + tmo + 6; k++) begin
        if (k == tmo - 1) chk("R8 lost before timeout", k, lostClk, 1'b0);
        if (k == tmo)     chk("R8 lost at timeout", k, lostClk, 1'b1);
        if (k == kPulse + 2) chk("R9 lost held before clear", k, lostClk, 1'b1);
        if (k == kPulse + 3) chk("R9 lost cleared by rise", k, lostClk, 1'b0);
        if (k == kPulse + 2 + tmo) chk("R8 lost before second timeout", k, lostClk, 1'b0);
        if (k == kPulse + 3 + tmo) chk("R8 lost at second timeout", k, lostClk, 1'b1);
        syncIn = (k == kPulse);
        @(negedge clk);
      end
    end

    // Periodic slave wave keeps the watchdog quiet (R8)
    begin
      timeoutCfg = WD_W'(20);
      doReset(1'b0);
      for (int k = 0; k <= 120; k++) begin
        chk("R8 lost with live sync", k, lostClk, 1'b0);
        syncIn = ((k % 9) >= 4);
        @(negedge clk);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule